// File: doc/BRIEF.md
# I2C Slave Receiver Controller

This block is the receive half of an I2C-bus slave. It follows the external SCL and SDA lines through a two-stage synchronizer. It detects START, repeated START and STOP conditions, and it shifts in the address byte. The 7-bit address is compared against four programmable slots. Each slot has an address byte and a mask byte, and a slot matches when every bit that the mask leaves in play is equal. The all-zero broadcast address is accepted when any slot enables it. When the block is addressed for a write, it acknowledges the address and then receives data bytes. For each data byte it sends ACK or NACK, depending on the acknowledge-enable bit.

Every bus event sets an event flag and loads a status code. After an acknowledge clock, the block also holds SCL low until software clears the flag. This gives software time to read the byte and choose the next response. All timing comes from the external SCL. A separate input reports lost arbitration from a master engine, so that the following address phase can be reported with its own codes. Software uses a small write port with set and clear strobes for the control bits, plus one word per slot for address and mask.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, `ctrl_q` reads 0x00, `stat_q` reads 0xF8, `irq` is 0 and both line drivers (`scl_oe`, `sda_oe`) are off.
- R2: A write to register 0 sets, and a write to register 1 clears, the control bits at their positions: enable = bit 6, STA = bit 5, STO = bit 4, event flag = bit 3, acknowledge-enable (AA) = bit 2. Bits 7, 1 and 0 always read 0. Software can clear the event flag but cannot set it, so writing 0xFF to register 0 reads back 0x74.
- R3: Registers 2..5 hold the slot addresses (7-bit address in bits 7:1, broadcast enable in bit 0). Registers 6..9 hold the slot masks, where a 1 in bits 7:1 excludes that address bit. An address byte with direction bit 0 that matches any slot, with AA = 1, is acknowledged and reports 0x60.
- R4: An address byte that matches no slot, or that carries direction bit 1 (read), gets no ACK and raises no event. The rest of the transfer up to the next START or STOP is ignored.
- R5: Address 0x00 with direction bit 0 is acknowledged with code 0x70 only when at least one slot has bit 0 set. Otherwise it gets no ACK and no event.
- R6: While addressed and with AA = 1, each data byte is acknowledged, is presented on `data_q` and reports 0x80 (own address) or 0x90 (broadcast).
- R7: If AA is 0 when a data byte completes, the block leaves SDA released for the acknowledge bit and reports 0x88 or 0x98. It then stops being addressed, so later bytes get no ACK and no event.
- R8: While AA is 0, no address is acknowledged. START and STOP are still tracked, so setting AA again makes the next START plus a matching address acknowledged.
- R9: A STOP or repeated START while addressed reports 0xA0, without holding SCL.
- R10: If `arb_lost_i` pulses during the address phase, a matching address reports 0x68 instead of 0x60, and a broadcast reports 0x78 instead of 0x70.
- R11: After every acknowledge clock the event flag is set and SCL is held low until software clears the flag. While the flag is 0, `stat_q` reads 0xF8.
- R12: Clearing the enable bit releases both lines at once, clears the event flag and returns the block to idle. Setting it again restores normal reception.
- R13: When a bus event and a software clear of the event flag fall in the same cycle, the event wins and the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock hold) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| arb_lost_i | input | 1 | Pulse: a master engine lost arbitration |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index (0 set, 1 clear, 2..5 address, 6..9 mask) |
| wr_data | input | 8 | Register write data |
| ctrl_q | output | 8 | Control register readback |
| stat_q | output | 8 | Status code |
| data_q | output | 8 | Last received data byte |
| irq | output | 1 | Event flag |

## Verification
Two things can land in the same clock cycle: the receiver raising its event flag (here on a STOP while addressed) and software writing the clear strobe for that flag. The bench provokes this by holding the clear-flag write active on every cycle across the whole STOP sequence, so that the collision is certain to occur. The result is judged by the scoreboard monitor, which must still see a rising flag carrying code 0xA0. If the clear were given priority, that expected item would stay in the queue and be reported.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

  // control bit positions
  localparam int CB_EN  = 6;
  localparam int CB_STA = 5;
  localparam int CB_STO = 4;
  localparam int CB_SI  = 3;
  localparam int CB_AA  = 2;

  // status codes
  localparam logic [7:0] SC_OWN_W     = 8'h60;
  localparam logic [7:0] SC_OWN_W_ARB = 8'h68;
  localparam logic [7:0] SC_GC        = 8'h70;
  localparam logic [7:0] SC_GC_ARB    = 8'h78;
  localparam logic [7:0] SC_DAT_ACK   = 8'h80;
  localparam logic [7:0] SC_DAT_NACK  = 8'h88;
  localparam logic [7:0] SC_GDAT_ACK  = 8'h90;
  localparam logic [7:0] SC_GDAT_NACK = 8'h98;
  localparam logic [7:0] SC_END       = 8'hA0;
  localparam logic [7:0] SC_NONE      = 8'hF8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_ADDR_ACK,
    RX_DATA,
    RX_DATA_ACK
  } rx_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], line_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int N_SLOTS = 4
) (
  input  logic [6:0]              addr_i,
  input  logic [N_SLOTS-1:0][7:0] adr_i,
  input  logic [N_SLOTS-1:0][7:0] msk_i,
  output logic                    own_hit_o,
  output logic                    gc_hit_o
);

  logic [N_SLOTS-1:0] slot_hit;
  logic [N_SLOTS-1:0] slot_gce;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_cmp
    assign slot_hit[g] = ((addr_i ^ adr_i[g][7:1]) & ~msk_i[g][7:1]) == 7'd0;
    assign slot_gce[g] = adr_i[g][0];
  end

  // the all-zero address is reserved for the broadcast
  assign own_hit_o = (|slot_hit) && (addr_i != 7'd0);
  assign gc_hit_o  = (addr_i == 7'd0) && (|slot_gce);

endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
  import i2c_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       aa_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_lvl_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       arb_lost_i,
  input  logic       own_hit_i,
  input  logic       gc_hit_i,
  output logic [6:0] addr_o,
  output logic       sda_drive_o,
  output logic [7:0] data_o,
  output logic       ev_valid_o,
  output logic [7:0] ev_code_o,
  output logic       ev_hold_o
);

  rx_state_e  st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] dat_q, dat_d;
  logic       act_q, act_d;
  logic       gc_q, gc_d;
  logic       ack_q, ack_d;
  logic       nk_q, nk_d;
  logic       arb_q, arb_d;

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    dat_d      = dat_q;
    act_d      = act_q;
    gc_d       = gc_q;
    ack_d      = ack_q;
    nk_d       = nk_q;
    arb_d      = arb_q | arb_lost_i;
    ev_valid_o = 1'b0;
    ev_code_o  = SC_NONE;
    ev_hold_o  = 1'b0;

    if (!en_i) begin
      st_d  = RX_IDLE;
      cnt_d = '0;
      act_d = 1'b0;
      gc_d  = 1'b0;
      ack_d = 1'b0;
      nk_d  = 1'b0;
      arb_d = 1'b0;
    end else if (stop_i) begin
      st_d  = RX_IDLE;
      ack_d = 1'b0;
      arb_d = 1'b0;
      act_d = 1'b0;
      if (act_q) begin
        ev_valid_o = 1'b1;
        ev_code_o  = SC_END;
      end
    end else if (start_i) begin
      st_d  = RX_ADDR;
      cnt_d = '0;
      ack_d = 1'b0;
      act_d = 1'b0;
      if (act_q) begin
        ev_valid_o = 1'b1;
        ev_code_o  = SC_END;
      end
    end else begin
      unique case (st_q)
        RX_IDLE: ;
        RX_ADDR: begin
          if (scl_rise_i && cnt_q < 4'd8) begin
            sh_d  = {sh_q[6:0], sda_lvl_i};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall_i && cnt_q == 4'd8) begin
            if (aa_i && !sh_q[0] && (own_hit_i || gc_hit_i)) begin
              st_d  = RX_ADDR_ACK;
              ack_d = 1'b1;
              gc_d  = gc_hit_i;
            end else begin
              st_d  = RX_IDLE;
              arb_d = 1'b0;
            end
          end
        end
        RX_ADDR_ACK: begin
          if (scl_fall_i) begin
            ack_d      = 1'b0;
            act_d      = 1'b1;
            arb_d      = 1'b0;
            st_d       = RX_DATA;
            cnt_d      = '0;
            ev_valid_o = 1'b1;
            ev_hold_o  = 1'b1;
            if (gc_q) ev_code_o = arb_q ? SC_GC_ARB : SC_GC;
            else      ev_code_o = arb_q ? SC_OWN_W_ARB : SC_OWN_W;
          end
        end
        RX_DATA: begin
          if (scl_rise_i && cnt_q < 4'd8) begin
            sh_d  = {sh_q[6:0], sda_lvl_i};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall_i && cnt_q == 4'd8) begin
            dat_d = sh_q;
            ack_d = aa_i;
            nk_d  = !aa_i;
            st_d  = RX_DATA_ACK;
          end
        end
        RX_DATA_ACK: begin
          if (scl_fall_i) begin
            ack_d      = 1'b0;
            ev_valid_o = 1'b1;
            ev_hold_o  = 1'b1;
            if (gc_q) ev_code_o = nk_q ? SC_GDAT_NACK : SC_GDAT_ACK;
            else      ev_code_o = nk_q ? SC_DAT_NACK : SC_DAT_ACK;
            if (nk_q) begin
              act_d = 1'b0;
              st_d  = RX_IDLE;
            end else begin
              st_d  = RX_DATA;
              cnt_d = '0;
            end
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      dat_q <= '0;
      act_q <= 1'b0;
      gc_q  <= 1'b0;
      ack_q <= 1'b0;
      nk_q  <= 1'b0;
      arb_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      dat_q <= dat_d;
      act_q <= act_d;
      gc_q  <= gc_d;
      ack_q <= ack_d;
      nk_q  <= nk_d;
      arb_q <= arb_d;
    end
  end

  assign addr_o      = sh_q[7:1];
  assign sda_drive_o = ack_q;
  assign data_o      = dat_q;

endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_rx_pkg::*;
#(
  parameter int N_SLOTS     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int RA_W       = $clog2(2 + 2 * N_SLOTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            scl_oe,
  output logic            sda_oe,
  input  logic            arb_lost_i,
  input  logic            wr_en,
  input  logic [RA_W-1:0] wr_addr,
  input  logic [7:0]      wr_data,
  output logic [7:0]      ctrl_q,
  output logic [7:0]      stat_q,
  output logic [7:0]      data_q,
  output logic            irq
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // line synchronizers
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_i_n), .line_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );
  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_i_n), .line_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  logic start_det, stop_det;
  assign start_det = scl_lvl & sda_fall;
  assign stop_det  = scl_lvl & sda_rise;

  // control and slot registers
  logic en_q, sta_q, sto_q, si_q, aa_q, hold_q;
  logic en_d, sta_d, sto_d, si_d, aa_d, hold_d;
  logic [7:0] code_q, code_d;
  logic [N_SLOTS-1:0][7:0] adr_q, adr_d, msk_q, msk_d;

  logic       wr_set, wr_clr;
  logic       ev_valid, ev_hold;
  logic [7:0] ev_code;

  assign wr_set = wr_en && (wr_addr == RA_W'(0));
  assign wr_clr = wr_en && (wr_addr == RA_W'(1));

  always_comb begin
    en_d   = en_q;
    sta_d  = sta_q;
    sto_d  = sto_q;
    si_d   = si_q;
    aa_d   = aa_q;
    hold_d = hold_q;
    code_d = code_q;
    adr_d  = adr_q;
    msk_d  = msk_q;

    if (wr_set) begin
      en_d  = en_q  | wr_data[CB_EN];
      sta_d = sta_q | wr_data[CB_STA];
      sto_d = sto_q | wr_data[CB_STO];
      aa_d  = aa_q  | wr_data[CB_AA];
    end
    if (wr_clr) begin
      en_d  = en_q  & ~wr_data[CB_EN];
      sta_d = sta_q & ~wr_data[CB_STA];
      sto_d = sto_q & ~wr_data[CB_STO];
      si_d  = si_q  & ~wr_data[CB_SI];
      aa_d  = aa_q  & ~wr_data[CB_AA];
    end
    for (int i = 0; i < N_SLOTS; i++) begin
      if (wr_en && wr_addr == RA_W'(2 + i))           adr_d[i] = wr_data;
      if (wr_en && wr_addr == RA_W'(2 + N_SLOTS + i)) msk_d[i] = wr_data;
    end
    // a bus event outranks a software clear in the same cycle
    if (ev_valid) begin
      si_d   = 1'b1;
      code_d = ev_code;
      hold_d = ev_hold;
    end
    if (!si_d) hold_d = 1'b0;
    if (!en_d) begin
      si_d   = 1'b0;
      hold_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      en_q   <= 1'b0;
      sta_q  <= 1'b0;
      sto_q  <= 1'b0;
      si_q   <= 1'b0;
      aa_q   <= 1'b0;
      hold_q <= 1'b0;
      code_q <= SC_NONE;
      adr_q  <= '0;
      msk_q  <= '0;
    end else begin
      en_q   <= en_d;
      sta_q  <= sta_d;
      sto_q  <= sto_d;
      si_q   <= si_d;
      aa_q   <= aa_d;
      hold_q <= hold_d;
      code_q <= code_d;
      adr_q  <= adr_d;
      msk_q  <= msk_d;
    end
  end

  // address comparators
  logic [6:0] rx_addr;
  logic       own_hit, gc_hit;

  i2c_addr_match #(.N_SLOTS(N_SLOTS)) u_match (
    .addr_i(rx_addr), .adr_i(adr_q), .msk_i(msk_q),
    .own_hit_o(own_hit), .gc_hit_o(gc_hit)
  );

  // receive engine
  logic sda_drive;

  i2c_rx_fsm u_fsm (
    .clk(clk), .rst_n(rst_i_n),
    .en_i(en_q), .aa_i(aa_q),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_lvl_i(sda_lvl),
    .start_i(start_det), .stop_i(stop_det),
    .arb_lost_i(arb_lost_i),
    .own_hit_i(own_hit), .gc_hit_i(gc_hit),
    .addr_o(rx_addr), .sda_drive_o(sda_drive), .data_o(data_q),
    .ev_valid_o(ev_valid), .ev_code_o(ev_code), .ev_hold_o(ev_hold)
  );

  assign sda_oe = sda_drive & en_q;
  assign scl_oe = si_q & hold_q;
  assign irq    = si_q;
  assign stat_q = si_q ? code_q : SC_NONE;
  assign ctrl_q = {1'b0, en_q, sta_q, sto_q, si_q, aa_q, 2'b00};

endmodule

// File: rtl/i2c_slave_rx_chk.sv
module i2c_slave_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [7:0] ctrl_q,
  input logic [7:0] stat_q,
  input logic       irq
);

  // R12
  disabled_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[6] |-> (!scl_oe && !sda_oe));

  // R11
  hold_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> irq);

  // R11
  idle_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (stat_q == 8'hF8));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[7] == 1'b0) && (ctrl_q[1:0] == 2'b00));

  // R7
  no_ack_under_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !sda_oe);

  // R11
  flag_mirrors_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (stat_q != 8'hF8));

endmodule

bind i2c_slave_rx i2c_slave_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .ctrl_q(ctrl_q), .stat_q(stat_q), .irq(irq)
);

// File: tb/tb_i2c_slave_rx.sv
module tb_i2c_slave_rx;

  localparam int Q = 5;
  localparam int H = 10;

  logic       clk;
  logic       rst_n;
  logic       arb_lost_i;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic       scl_oe, sda_oe, irq;
  logic [7:0] ctrl_q, stat_q, data_q;
  logic       m_scl_low, m_sda_low;
  logic       scl_line, sda_line;

  assign scl_line = !(m_scl_low | scl_oe);
  assign sda_line = !(m_sda_low | sda_oe);

  i2c_slave_rx dut (
    .clk(clk), .rst_n(rst_n),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .arb_lost_i(arb_lost_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .stat_q(stat_q), .data_q(data_q), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    string      req;
    logic [7:0] code;
    logic [7:0] data;
    bit         cd;
  } ev_t;
  ev_t exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push_ev(input string req, input logic [7:0] code, input logic [7:0] data, input bit cd);
    ev_t e;
    e.req = req; e.code = code; e.data = data; e.cd = cd;
    exp_q.push_back(e);
  endtask

  // scoreboard monitor
  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (irq && !prev) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "unexpected event", {24'd0, stat_q}, 32'd0);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk(stat_q == e.code, e.req, {24'd0, stat_q}, {24'd0, e.code});
          if (e.cd) chk(data_q == e.data, e.req, {24'd0, data_q}, {24'd0, e.data});
        end
      end
      prev = irq;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic scl_release();
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; m_scl_low = 1'b0; wait_cyc(H);
    m_sda_low = 1'b1; wait_cyc(H);
    m_scl_low = 1'b1; wait_cyc(Q);
  endtask

  task automatic bus_rstart();
    m_sda_low = 1'b0; wait_cyc(Q);
    scl_release(); wait_cyc(H);
    m_sda_low = 1'b1; wait_cyc(H);
    m_scl_low = 1'b1; wait_cyc(Q);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wait_cyc(Q);
    scl_release(); wait_cyc(H);
    m_sda_low = 1'b0; wait_cyc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = !b[i]; wait_cyc(Q);
      scl_release(); wait_cyc(H);
      m_scl_low = 1'b1; wait_cyc(Q);
    end
    m_sda_low = 1'b0; wait_cyc(Q);
    scl_release(); wait_cyc(Q);
    ack = !sda_line;
    wait_cyc(Q);
    m_scl_low = 1'b1; wait_cyc(Q);
  endtask

  task automatic xfer(input logic [7:0] b, input bit exp_ack, input string req);
    logic a;
    send_byte(b, a);
    chk(a == exp_ack, req, {31'd0, a}, {31'd0, exp_ack});
  endtask

  task automatic wait_irq(input string req);
    int n;
    n = 0;
    while (!irq && n < 100) begin @(negedge clk); n++; end
    chk(irq == 1'b1, req, {31'd0, irq}, 32'd1);
  endtask

  task automatic take_si(input string req);
    wait_irq(req);
    wr(4'd1, 8'h08);
    wait_cyc(2);
  endtask

  task automatic no_si(input string req);
    wait_cyc(30);
    chk(irq == 1'b0, req, {31'd0, irq}, 32'd0);
  endtask

  task automatic arb_pulse();
    @(negedge clk); arb_lost_i = 1'b1;
    @(negedge clk); arb_lost_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; arb_lost_i = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    m_scl_low = 1'b0; m_sda_low = 1'b0;
    wait_cyc(5);
    // R1 reset state
    chk(ctrl_q == 8'h00, "R1", {24'd0, ctrl_q}, 32'h00);
    chk(stat_q == 8'hF8, "R1", {24'd0, stat_q}, 32'hF8);
    chk(!irq && !scl_oe && !sda_oe, "R1", {29'd0, irq, scl_oe, sda_oe}, 32'd0);
    rst_n = 1'b1;
    wait_cyc(5);

    // R2 set / clear control bits
    wr(4'd0, 8'hFF);
    chk(ctrl_q == 8'h74, "R2", {24'd0, ctrl_q}, 32'h74);
    wr(4'd1, 8'h30);
    chk(ctrl_q == 8'h44, "R2", {24'd0, ctrl_q}, 32'h44);

    wr(4'd2, 8'h50); wr(4'd6, 8'h00);
    wr(4'd3, 8'hA0); wr(4'd7, 8'h0E);
    wr(4'd4, 8'h20); wr(4'd8, 8'h00);
    wr(4'd5, 8'hFE); wr(4'd9, 8'h00);

    // R3 exact slot, R11 clock hold
    push_ev("R3", 8'h60, 8'h00, 0);
    bus_start(); xfer(8'h50, 1, "R3");
    wait_irq("R11");
    m_scl_low = 1'b0; wait_cyc(6);
    chk(scl_line == 1'b0, "R11", {31'd0, scl_line}, 32'd0);
    m_scl_low = 1'b1;
    wr(4'd1, 8'h08); wait_cyc(3);
    chk(scl_oe == 1'b0, "R11", {31'd0, scl_oe}, 32'd0);
    chk(stat_q == 8'hF8, "R11", {24'd0, stat_q}, 32'hF8);
    push_ev("R6", 8'h80, 8'hA5, 1);
    xfer(8'hA5, 1, "R6"); take_si("R6");
    push_ev("R9", 8'hA0, 8'h00, 0);
    bus_stop(); take_si("R9");

    // R3 masked slot, R9 repeated start, R4 mismatch
    push_ev("R3", 8'h60, 8'h00, 0);
    bus_start(); xfer(8'hAA, 1, "R3"); take_si("R3");
    push_ev("R6", 8'h80, 8'h3C, 1);
    xfer(8'h3C, 1, "R6"); take_si("R6");
    push_ev("R9", 8'hA0, 8'h00, 0);
    bus_rstart(); take_si("R9");
    xfer(8'hB0, 0, "R4"); no_si("R4");
    bus_stop(); no_si("R4");

    // R4 read direction
    bus_start(); xfer(8'h51, 0, "R4");
    bus_stop(); no_si("R4");

    // R5 broadcast disabled then enabled
    bus_start(); xfer(8'h00, 0, "R5");
    bus_stop(); no_si("R5");
    wr(4'd4, 8'h21);
    push_ev("R5", 8'h70, 8'h00, 0);
    bus_start(); xfer(8'h00, 1, "R5"); take_si("R5");
    push_ev("R6", 8'h90, 8'h11, 1);
    xfer(8'h11, 1, "R6"); take_si("R6");
    push_ev("R9", 8'hA0, 8'h00, 0);
    bus_stop(); take_si("R9");

    // R7 AA cleared during transfer
    push_ev("R7", 8'h60, 8'h00, 0);
    bus_start(); xfer(8'h50, 1, "R7"); take_si("R7");
    push_ev("R7", 8'h80, 8'h01, 1);
    xfer(8'h01, 1, "R7"); wait_irq("R7");
    wr(4'd1, 8'h04);
    chk(ctrl_q == 8'h48, "R7", {24'd0, ctrl_q}, 32'h48);
    wr(4'd1, 8'h08);
    push_ev("R7", 8'h88, 8'h02, 1);
    xfer(8'h02, 0, "R7"); take_si("R7");
    xfer(8'h03, 0, "R7"); no_si("R7");
    bus_stop(); no_si("R7");

    // R8 detached, then reattached
    bus_start(); xfer(8'h50, 0, "R8"); no_si("R8");
    wr(4'd0, 8'h04);
    push_ev("R8", 8'h60, 8'h00, 0);
    bus_rstart(); xfer(8'h50, 1, "R8"); take_si("R8");
    push_ev("R9", 8'hA0, 8'h00, 0);
    bus_stop(); take_si("R9");

    // R10 lost arbitration
    push_ev("R10", 8'h68, 8'h00, 0);
    bus_start(); arb_pulse(); xfer(8'h50, 1, "R10"); take_si("R10");
    push_ev("R9", 8'hA0, 8'h00, 0);
    bus_stop(); take_si("R9");
    push_ev("R10", 8'h78, 8'h00, 0);
    bus_start(); arb_pulse(); xfer(8'h00, 1, "R10"); take_si("R10");
    push_ev("R10", 8'h90, 8'h77, 1);
    xfer(8'h77, 1, "R10"); take_si("R10");
    push_ev("R9", 8'hA0, 8'h00, 0);
    bus_stop(); take_si("R9");

    // R12 disable mid transfer
    push_ev("R12", 8'h60, 8'h00, 0);
    bus_start(); xfer(8'h50, 1, "R12"); wait_irq("R12");
    wr(4'd1, 8'h40); wait_cyc(3);
    chk(!scl_oe && !sda_oe && !irq, "R12", {29'd0, scl_oe, sda_oe, irq}, 32'd0);
    chk(stat_q == 8'hF8, "R12", {24'd0, stat_q}, 32'hF8);
    chk(ctrl_q == 8'h04, "R12", {24'd0, ctrl_q}, 32'h04);
    bus_stop();
    wr(4'd0, 8'h40);
    push_ev("R12", 8'h60, 8'h00, 0);
    bus_start(); xfer(8'h50, 1, "R12"); take_si("R12");
    push_ev("R9", 8'hA0, 8'h00, 0);
    bus_stop(); take_si("R9");

    // R13 event against simultaneous clear
    push_ev("R13", 8'h60, 8'h00, 0);
    bus_start(); xfer(8'h50, 1, "R13"); take_si("R13");
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd1; wr_data = 8'h08;
    push_ev("R13", 8'hA0, 8'h00, 0);
    bus_stop();
    wait_cyc(5);
    wr_en = 1'b0;
    wait_cyc(5);
    chk(exp_q.size() == 0, "R13", exp_q.size(), 32'd0);

    wait_cyc(20);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 32'd0);
    finish_run();
  end

endmodule